// File: doc/BRIEF.md
# Iterative AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key. A single input selects the direction. The key it receives has already been wrapped by a stream-cipher stage upstream, and the engine treats it as an ordinary AES key. When a request is accepted, the engine builds the whole 44-word round-key schedule in a local memory, one word per clock. It then runs one initial key addition followed by ten rounds, one round per clock, on a 4x4 byte state.

Both directions use the same schedule memory. Encryption reads the round keys from round 0 up to round 10. Decryption reads them from round 10 down to round 0 and uses the inverse round operations. Requests enter through a valid/ready handshake, and the engine accepts no new request until the current one has finished. The result is marked by a one-cycle valid pulse and stays on the output until the next request is accepted.

Top module: `aes_iter_core`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle in which the result is presented.
- R3: `out_valid` rises exactly 51 clock edges after the accepting edge and lasts one cycle. The 51 edges are 40 schedule words, one initial key addition and ten rounds.
- R4: With `in_decrypt` = 0, `out_block` is the AES-128 encryption of `in_block` under `in_key`. Byte 0 of each vector is bits 127:120. Bytes fill the state column by column (byte 4c+r goes to row r, column c), and round keys are taken from the schedule as words 0-3, 4-7 and so on.
- R5: With `in_decrypt` = 1, `out_block` is the AES-128 decryption of `in_block` under `in_key`. Round keys are applied from words 40-43 down to words 0-3.
- R6: The schedule is rebuilt from `in_key` on every accepted request. A new key gives correct results without any other action.
- R7: Changes on `in_valid`, `in_decrypt`, `in_block` and `in_key` while `in_ready` is 0 have no effect on the result.
- R8: `in_ready` is 1 in the cycle where `out_valid` is 1. `out_block` keeps its value while the engine is idle and no request is accepted.
- R9: The last round leaves out the column mixing step in both directions. Shift rows rotates rows 1 to 3 left by 1 to 3 bytes, and the inverse rotates them right by the same amounts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_decrypt | input | 1 | 1 selects decryption, 0 encryption |
| in_block | input | 128 | Plaintext or ciphertext, byte 0 in bits 127:120 |
| in_key | input | 128 | Wrapped cipher key, byte 0 in bits 127:120 |
| out_valid | output | 1 | One-cycle result strobe |
| out_block | output | 128 | Result block, held while idle |

## Verification
The hardest case to reach is a decryption that depends on the last schedule words being complete at the exact cycle the first key addition reads them, and on an earlier request's schedule not leaking into it. The bench therefore alternates directions and changes keys between operations, so every schedule is written from scratch and read in the opposite order from the one before. During one decryption it also holds `in_valid` high with an inverted block, key and direction through the busy window. A leak in the handshake would then corrupt the checked result.

// File: rtl/aes_pkg.sv
package aes_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXPAND = 2'd1,
        PH_ROUND  = 2'd2
    } phase_e;

    // multiply by x in GF(2^8) with the AES reduction polynomial
    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xt(x);
        end
        return p;
    endfunction

    // a^254 is the multiplicative inverse, and 0 maps to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] sq;
        r  = 8'h01;
        sq = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gmul(r, sq);
            sq = gmul(sq, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] inv_sbox(input logic [7:0] a);
        return gf_inv(rotl(a, 1) ^ rotl(a, 3) ^ rotl(a, 6) ^ 8'h05);
    endfunction

    function automatic logic [31:0] mixcol(input logic [31:0] c);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {gmul(a0, 8'h02) ^ gmul(a1, 8'h03) ^ a2 ^ a3,
                a0 ^ gmul(a1, 8'h02) ^ gmul(a2, 8'h03) ^ a3,
                a0 ^ a1 ^ gmul(a2, 8'h02) ^ gmul(a3, 8'h03),
                gmul(a0, 8'h03) ^ a1 ^ a2 ^ gmul(a3, 8'h02)};
    endfunction

    function automatic logic [31:0] inv_mixcol(input logic [31:0] c);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
                gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
                gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
                gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
    endfunction

endpackage

// File: rtl/aes_round_dp.sv
// One full round in either direction; purely combinational.
module aes_round_dp
    import aes_pkg::*;
(
    input  logic [127:0] state_i,
    input  logic [127:0] rkey_i,
    input  logic         decrypt_i,
    input  logic         last_i,
    output logic [127:0] state_o
);

    logic [127:0] sub_e;   // shifted then substituted, forward
    logic [127:0] sub_d;   // inverse shifted then inverse substituted
    logic [127:0] mix_e;
    logic [127:0] keyed_d;
    logic [127:0] mix_d;

    assign keyed_d = sub_d ^ rkey_i;

    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int DST   = 4 * c + r;
            localparam int SRC_E = 4 * ((c + r) % 4) + r;
            localparam int SRC_D = 4 * ((c + 4 - r) % 4) + r;
            assign sub_e[127 - 8 * DST -: 8] = sbox(state_i[127 - 8 * SRC_E -: 8]);
            assign sub_d[127 - 8 * DST -: 8] = inv_sbox(state_i[127 - 8 * SRC_D -: 8]);
        end
        assign mix_e[127 - 32 * c -: 32] = mixcol(sub_e[127 - 32 * c -: 32]);
        assign mix_d[127 - 32 * c -: 32] = inv_mixcol(keyed_d[127 - 32 * c -: 32]);
    end

    always_comb begin
        if (decrypt_i) state_o = last_i ? keyed_d : mix_d;
        else           state_o = (last_i ? sub_e : mix_e) ^ rkey_i;
    end

endmodule

// File: rtl/aes_key_sched.sv
// Round-key memory, filled one word per clock after a load.
module aes_key_sched
    import aes_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [127:0]                 key_i,
    input  logic [$clog2(NR + 1) - 1:0]  rd_round_i,
    output logic [127:0]                 rkey_o,
    output logic                         done_o
);

    localparam int NW = 4 * (NR + 1);
    localparam int IW = $clog2(NW + 1);
    localparam int RW = $clog2(NR + 1);

    logic [31:0]   mem [NW];
    logic [IW-1:0] idx_d, idx_q;
    logic [7:0]    rcon_d, rcon_q;
    logic [31:0]   prev_w, rot_w, sub_w, tmp_w, new_w;
    logic [RW-1:0] rsel;

    always_comb begin
        done_o = (idx_q == IW'(NW));
        prev_w = mem[idx_q - IW'(1)];
        rot_w  = {prev_w[23:0], prev_w[31:24]};
        sub_w  = {sbox(rot_w[31:24]), sbox(rot_w[23:16]), sbox(rot_w[15:8]), sbox(rot_w[7:0])};
        tmp_w  = (idx_q[1:0] == 2'b00) ? (sub_w ^ {rcon_q, 24'h0}) : prev_w;
        new_w  = tmp_w ^ mem[idx_q - IW'(4)];

        idx_d  = idx_q;
        rcon_d = rcon_q;
        if (load_i) begin
            idx_d  = IW'(4);
            rcon_d = 8'h01;
        end else if (!done_o) begin
            idx_d = idx_q + IW'(1);
            if (idx_q[1:0] == 2'b00) rcon_d = xt(rcon_q);
        end

        rsel = (rd_round_i > RW'(NR)) ? RW'(NR) : rd_round_i;
        for (int k = 0; k < 4; k++) begin
            rkey_o[127 - 32 * k -: 32] = mem[IW'(4 * int'(rsel) + k)];
        end
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            for (int k = 0; k < 4; k++) mem[k] <= key_i[127 - 32 * k -: 32];
        end else if (!done_o) begin
            mem[idx_q] <= new_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= IW'(NW);
            rcon_q <= 8'h01;
        end else begin
            idx_q  <= idx_d;
            rcon_q <= rcon_d;
        end
    end

endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
    import aes_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_decrypt,
    input  logic [127:0] in_block,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_block
);

    localparam int RW = $clog2(NR + 1);

    typedef struct packed {
        phase_e        ph;
        logic          dec;
        logic [RW-1:0] rnd;
        logic [127:0]  st;
        logic          ovld;
    } core_s;

    localparam core_s CORE_RST = '{ph: PH_IDLE, dec: 1'b0, rnd: '0, st: '0, ovld: 1'b0};

    core_s         q, d;
    logic          ks_load, ks_done, last_rnd;
    logic [RW-1:0] ks_sel;
    logic [127:0]  rkey, rnd_out;

    aes_key_sched #(.NR(NR)) ks_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ks_load),
        .key_i      (in_key),
        .rd_round_i (ks_sel),
        .rkey_o     (rkey),
        .done_o     (ks_done)
    );

    aes_round_dp rdp_i (
        .state_i   (q.st),
        .rkey_i    (rkey),
        .decrypt_i (q.dec),
        .last_i    (last_rnd),
        .state_o   (rnd_out)
    );

    always_comb begin
        d        = q;
        d.ovld   = 1'b0;
        ks_load  = 1'b0;
        last_rnd = (q.rnd == RW'(NR));
        if (q.ph == PH_EXPAND) ks_sel = q.dec ? RW'(NR) : '0;
        else                   ks_sel = q.dec ? (RW'(NR) - q.rnd) : q.rnd;

        case (q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    ks_load = 1'b1;
                    d.ph    = PH_EXPAND;
                    d.dec   = in_decrypt;
                    d.st    = in_block;
                end
            end
            PH_EXPAND: begin
                if (ks_done) begin
                    d.st  = q.st ^ rkey;
                    d.rnd = RW'(1);
                    d.ph  = PH_ROUND;
                end
            end
            PH_ROUND: begin
                d.st = rnd_out;
                if (last_rnd) begin
                    d.ph   = PH_IDLE;
                    d.ovld = 1'b1;
                end else begin
                    d.rnd = q.rnd + RW'(1);
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign in_ready  = (q.ph == PH_IDLE);
    assign out_valid = q.ovld;
    assign out_block = q.st;

endmodule

// File: rtl/aes_iter_core_chk.sv
module aes_iter_core_chk #(
    parameter int NR = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic [127:0] out_block
);

    localparam int LAT = 4 * NR + 1 + NR;

    logic        armed_q;
    logic [15:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (in_valid && in_ready) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (armed_q) begin
            cnt_q <= cnt_q + 16'd1;
            if (out_valid) armed_q <= 1'b0;
        end
    end

    p_busy_after_accept_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_latency_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (armed_q && cnt_q == 16'(LAT)));

    p_single_pulse_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_ready_with_result_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    p_hold_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(out_block));

endmodule

bind aes_iter_core aes_iter_core_chk #(.NR(NR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_block (out_block)
);

// File: tb/aes_iter_core_tb_top.sv
module aes_iter_core_tb_top;

    localparam int EXP_LAT = 51;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_decrypt = 1'b0;
    logic [127:0] in_block = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic [127:0] out_block;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

    aes_iter_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_decrypt (in_decrypt),
        .in_block   (in_block),
        .in_key     (in_key),
        .out_valid  (out_valid),
        .out_block  (out_block)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'd1);
        check(out_valid === 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);
    endtask

    // one request; optionally drives conflicting inputs while busy (R7)
    task automatic run_op(input bit dec, input logic [127:0] blk, input logic [127:0] key,
                          input logic [127:0] exp, input bit junk, input string req);
        int           lat;
        bit           busy_ok;
        logic [127:0] res;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid   = 1'b1;
        in_decrypt = dec;
        in_block   = blk;
        in_key     = key;
        @(negedge clk);
        in_valid = 1'b0;
        in_block = ~blk;
        in_key   = ~key;
        lat      = 0;
        busy_ok  = 1'b1;
        for (int k = 0; k < 200; k++) begin
            if (out_valid) break;
            if (in_ready) busy_ok = 1'b0;
            in_valid   = junk;
            in_decrypt = junk ? ~dec : dec;
            @(negedge clk);
            lat++;
        end
        in_valid = 1'b0;
        res = out_block;
        check(out_valid === 1'b1, "R3 result strobe seen", 128'(out_valid), 128'd1);
        check(res === exp, req, res, exp);
        check(lat == EXP_LAT, "R3 latency from accept", 128'(lat), 128'(EXP_LAT));
        check(busy_ok, "R2 in_ready low while busy", 128'(busy_ok), 128'd1);
        check(in_ready === 1'b1, "R8 ready with result", 128'(in_ready), 128'd1);
        @(negedge clk);
        check(out_valid === 1'b0, "R3 strobe lasts one cycle", 128'(out_valid), 128'd0);
        repeat (3) @(negedge clk);
        check(out_block === res, "R8 result held while idle", out_block, res);
    endtask

    task automatic t_enc_first();
        run_op(1'b0, P1, K1, C1, 1'b0, "R4/R9 encrypt vector one");
    endtask

    task automatic t_dec_first();
        run_op(1'b1, C1, K1, P1, 1'b0, "R5/R9 decrypt vector one");
    endtask

    task automatic t_enc_newkey();
        run_op(1'b0, P2, K2, C2, 1'b0, "R6 encrypt under new key");
    endtask

    task automatic t_dec_junk();
        run_op(1'b1, C2, K2, P2, 1'b1, "R7 decrypt with busy-time input noise");
    endtask

    task automatic t_rekey_back();
        run_op(1'b0, P1, K1, C1, 1'b0, "R6 schedule rebuilt for old key");
    endtask

    initial begin
        t_reset();
        t_enc_first();
        t_dec_first();
        t_enc_newkey();
        t_dec_junk();
        t_rekey_back();
        summary();
        $finish;
    end

endmodule